// File: doc/BRIEF.md
# Armed External Trigger Start Controller

This block sits in the sample-clock domain of a converter data path. Software can arm it so that the path starts on an external trigger, once. A write of 1 to the arm control bit puts the block in its waiting state. While it waits, it holds the data path in reset. The status output reads 1 during the wait. The first rising edge on the chosen trigger input releases the reset, clears the status and clears the control bit. The trigger inputs are taken as already synchronous to the local clock, so no synchronizer stage is added.

Two trigger sources are available: a plain external sync line and a periodic alignment pulse line. A select input picks one of them, and only a fresh rising edge of the selected line counts. A periodic pulse that is already high when the block is armed therefore does not fire it. Software must still stop that pulse train before arming, so that the first edge seen is the intended one. When the parameter `EXT_SYNC` is 0, the external path is switched off and the older software start is kept: a write to the control bit gives a data-path reset pulse of fixed length, the status stays 0 and trigger inputs have no effect.

Top module: `ext_sync_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears `sync_armed`, `arm_ctl` and `dp_rst`, and all three read 0 in the cycle after a clock edge that samples `rst` high.
- R2: With `EXT_SYNC`=1, a clock edge that samples `arm_wr`=1 while the block is idle makes `sync_armed`, `arm_ctl` and `dp_rst` all 1 from the next cycle on.
- R3: While armed and with no rising edge on the selected trigger, `sync_armed`, `arm_ctl` and `dp_rst` stay 1.
- R4: A rising edge means the selected trigger is 1 at a clock edge after it was 0 at the clock edge before. When a rising edge is sampled while armed, `sync_armed`, `arm_ctl` and `dp_rst` all fall together after that same edge, and they stay 0 afterwards.
- R5: A trigger level that is already high when the block is armed does not fire it. Only a later 0-to-1 transition does.
- R6: A rising edge sampled while the block is idle is ignored: the outputs stay 0, and a later arm still waits for a new edge.
- R7: `arm_wr`=1 while the block is already armed has no effect. The block stays armed and the next rising edge releases it.
- R8: `src_sel`=0 selects `ext_sync` as the trigger, and `src_sel`=1 selects `sysref`. Edges on the input that is not selected have no effect.
- R9: If `arm_wr` and a rising edge are sampled at the same clock edge, an idle block becomes armed and does not take the edge, and an armed block takes the trigger and becomes idle.
- R10: With `EXT_SYNC`=0, `arm_wr` makes `dp_rst` 1 for exactly `RST_PULSE_LEN` cycles starting the cycle after it is sampled. A new `arm_wr` during the pulse restarts the full length. `sync_armed` and `arm_ctl` stay 0, and trigger inputs are ignored.
- R11: `rst` sampled while armed disarms the block and releases `dp_rst` after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter data-path clock |
| rst | input | 1 | Synchronous reset, active high |
| arm_wr | input | 1 | One-cycle strobe: software writes 1 to the arm bit |
| ext_sync | input | 1 | External sync line, already synchronous to clk |
| sysref | input | 1 | Periodic alignment pulse line, already synchronous to clk |
| src_sel | input | 1 | Trigger source: 0 = ext_sync, 1 = sysref |
| arm_ctl | output | 1 | Readback of the self-clearing arm control bit |
| sync_armed | output | 1 | Status: armed and waiting for the trigger |
| dp_rst | output | 1 | Reset/hold for the data path |

## Verification
The arm write and the trigger edge can land on the same clock edge, and the outcome depends on the state at that edge. The bench produces this collision twice: once from idle, where the block must end up armed and ignore the edge, and once while armed, where the trigger must win and the block must end up idle. A reference model predicts the outputs for every cycle. After each edge the status, control readback and reset are compared with that prediction, so a wrong priority shows up in the very next cycle.

// File: rtl/ext_sync_pkg.sv
package ext_sync_pkg;

    typedef enum logic {
        TRIG_SRC_EXT    = 1'b0,
        TRIG_SRC_SYSREF = 1'b1
    } trig_src_e;

    typedef struct packed {
        logic armed;
    } arm_state_t;

endpackage

// File: rtl/esc_trig_mux.sv
module esc_trig_mux
    import ext_sync_pkg::*;
(
    input  logic      ext_sync,
    input  logic      sysref,
    input  trig_src_e src,
    output logic      trig
);

    always_comb begin
        unique case (src)
            TRIG_SRC_SYSREF: trig = sysref;
            default:         trig = ext_sync;
        endcase
    end

endmodule

// File: rtl/esc_rise_det.sv
module esc_rise_det (
    input  logic clk,
    input  logic sig,
    output logic rise
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig;
        rise   = sig & ~prev_q;
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end

endmodule

// File: rtl/esc_arm_fsm.sv
module esc_arm_fsm
    import ext_sync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm_req,
    input  logic rise,
    output logic armed
);

    arm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.armed) begin
            // armed: only the trigger edge matters, a repeated arm is moot
            if (rise) begin
                st_d.armed = 1'b0;
            end
        end else if (arm_req) begin
            // idle: an edge in the arming cycle is not taken
            st_d.armed = 1'b1;
        end
        if (rst) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign armed = st_q.armed;

endmodule

// File: rtl/esc_sw_pulse.sv
module esc_sw_pulse #(
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active
);

    localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pulse_state_t;

    pulse_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt = LOAD_VAL;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (rst) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign active = (st_q.cnt != '0);

endmodule

// File: rtl/ext_sync_ctrl.sv
module ext_sync_ctrl
    import ext_sync_pkg::*;
#(
    parameter int unsigned EXT_SYNC      = 1,
    parameter int unsigned RST_PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_wr,
    input  logic ext_sync,
    input  logic sysref,
    input  logic src_sel,
    output logic arm_ctl,
    output logic sync_armed,
    output logic dp_rst
);

    localparam bit EXT_EN = (EXT_SYNC != 0);

    logic trig, rise, armed, pulse_on;
    logic arm_req, sw_start;

    generate
        if (EXT_EN) begin : g_ext
            assign arm_req  = arm_wr;
            assign sw_start = 1'b0;
        end else begin : g_legacy
            assign arm_req  = 1'b0;
            assign sw_start = arm_wr;
        end
    endgenerate

    esc_trig_mux u_mux (
        .ext_sync (ext_sync),
        .sysref   (sysref),
        .src      (trig_src_e'(src_sel)),
        .trig     (trig)
    );

    esc_rise_det u_rise (
        .clk  (clk),
        .sig  (trig),
        .rise (rise)
    );

    esc_arm_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .arm_req (arm_req),
        .rise    (rise),
        .armed   (armed)
    );

    esc_sw_pulse #(
        .PULSE_LEN (RST_PULSE_LEN)
    ) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .start  (sw_start),
        .active (pulse_on)
    );

    assign arm_ctl    = armed;
    assign sync_armed = armed;
    assign dp_rst     = armed | pulse_on;

endmodule

// File: rtl/ext_sync_ctrl_chk.sv
module ext_sync_ctrl_chk #(
    parameter int unsigned EXT_SYNC = 1
) (
    input logic clk,
    input logic rst,
    input logic arm_wr,
    input logic ext_sync,
    input logic sysref,
    input logic src_sel,
    input logic arm_ctl,
    input logic sync_armed,
    input logic dp_rst
);

    logic trig_c;
    assign trig_c = src_sel ? sysref : ext_sync;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!sync_armed && !arm_ctl && !dp_rst)); // R1

    generate
        if (EXT_SYNC != 0) begin : g_ext_chk
            AST_ARM_TAKES: assert property (@(posedge clk) disable iff (rst)
                (!sync_armed && arm_wr) |=> (sync_armed && arm_ctl && dp_rst)); // R2

            AST_HOLD_ARMED: assert property (@(posedge clk) disable iff (rst)
                (sync_armed && !(trig_c && !$past(trig_c))) |=> (sync_armed && dp_rst)); // R3

            AST_TRIG_RELEASES: assert property (@(posedge clk) disable iff (rst)
                (sync_armed && trig_c && !$past(trig_c)) |=> (!sync_armed && !arm_ctl && !dp_rst)); // R4

            AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (rst)
                (!sync_armed && !arm_wr) |=> (!sync_armed && !dp_rst)); // R6
        end else begin : g_leg_chk
            AST_LEG_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
                arm_wr |-> (!sync_armed && !arm_ctl)); // R10

            AST_LEG_PULSE: assert property (@(posedge clk) disable iff (rst)
                arm_wr |=> (dp_rst && !sync_armed)); // R10
        end
    endgenerate

endmodule

bind ext_sync_ctrl ext_sync_ctrl_chk #(
    .EXT_SYNC (EXT_SYNC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .arm_wr     (arm_wr),
    .ext_sync   (ext_sync),
    .sysref     (sysref),
    .src_sel    (src_sel),
    .arm_ctl    (arm_ctl),
    .sync_armed (sync_armed),
    .dp_rst     (dp_rst)
);

// File: tb/ext_sync_ctrl_test.sv
module ext_sync_ctrl_test;

    localparam int unsigned LEN = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm_wr = 1'b0;
    logic ext_sync = 1'b0;
    logic sysref = 1'b0;
    logic src_sel = 1'b0;

    logic arm_ctl, sync_armed, dp_rst;
    logic l_arm_ctl, l_sync_armed, l_dp_rst;

    always #5 clk = ~clk;

    ext_sync_ctrl #(.EXT_SYNC(1), .RST_PULSE_LEN(LEN)) uut (
        .clk(clk), .rst(rst), .arm_wr(arm_wr), .ext_sync(ext_sync),
        .sysref(sysref), .src_sel(src_sel),
        .arm_ctl(arm_ctl), .sync_armed(sync_armed), .dp_rst(dp_rst)
    );

    ext_sync_ctrl #(.EXT_SYNC(0), .RST_PULSE_LEN(LEN)) uut_leg (
        .clk(clk), .rst(rst), .arm_wr(arm_wr), .ext_sync(ext_sync),
        .sysref(sysref), .src_sel(src_sel),
        .arm_ctl(l_arm_ctl), .sync_armed(l_sync_armed), .dp_rst(l_dp_rst)
    );

    typedef struct {
        string tag;
        logic  e_armed;
        logic  l_rst;
    } exp_t;

    exp_t sb[$];
    int   compared = 0;
    int   mismatched = 0;
    bit   done = 1'b0;

    logic m_armed = 1'b0;
    logic m_prev = 1'b0;
    int   m_cnt = 0;

    task automatic step(input logic a, input logic e, input logic s,
                        input logic sl, input logic r, input string tag);
        exp_t it;
        logic t, rs;
        @(negedge clk);
        arm_wr = a; ext_sync = e; sysref = s; src_sel = sl; rst = r;
        t  = sl ? s : e;
        rs = t && !m_prev;
        if (r) m_armed = 1'b0;
        else if (m_armed && rs) m_armed = 1'b0;
        else if (!m_armed && a) m_armed = 1'b1;
        m_prev = t;
        if (r) m_cnt = 0;
        else if (a) m_cnt = LEN;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        it.tag = tag;
        it.e_armed = m_armed;
        it.l_rst = (m_cnt != 0);
        sb.push_back(it);
    endtask

    initial begin : monitor
        exp_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                compared++;
                if (sync_armed !== it.e_armed || arm_ctl !== it.e_armed ||
                    dp_rst !== it.e_armed || l_sync_armed !== 1'b0 ||
                    l_arm_ctl !== 1'b0 || l_dp_rst !== it.l_rst) begin
                    mismatched++;
                    $display("FAIL %s: act armed=%b ctl=%b rst=%b leg(armed=%b ctl=%b rst=%b) exp armed=%b ctl=%b rst=%b leg(armed=0 ctl=0 rst=%b)",
                             it.tag, sync_armed, arm_ctl, dp_rst,
                             l_sync_armed, l_arm_ctl, l_dp_rst,
                             it.e_armed, it.e_armed, it.e_armed, it.l_rst);
                end
            end
        end
    end

    initial begin : watchdog
        #200000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : driver
        // R1: reset state
        step(0, 0, 0, 0, 1, "R1");
        step(0, 0, 0, 0, 1, "R1");
        // R6: edge while idle ignored
        step(0, 1, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 0, "R6");
        // R2 arm, R3 hold
        step(1, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, "R3");
        // R7: arm while armed
        step(1, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, "R7");
        // R4: trigger releases, stays released
        step(0, 1, 0, 0, 0, "R4");
        step(0, 1, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 0, "R4");
        // R5: level already high at arming
        step(0, 1, 0, 0, 0, "R6");
        step(1, 1, 0, 0, 0, "R5");
        step(0, 1, 0, 0, 0, "R5");
        step(0, 1, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, "R3");
        step(0, 1, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, "R5");
        // R8: sysref selected, ext edges ignored
        step(0, 0, 0, 1, 0, "R8");
        step(1, 0, 0, 1, 0, "R8");
        step(0, 1, 0, 1, 0, "R8");
        step(0, 0, 0, 1, 0, "R8");
        step(0, 0, 1, 1, 0, "R8");
        step(0, 0, 0, 1, 0, "R8");
        // R8: ext selected, sysref edges ignored
        step(1, 0, 0, 0, 0, "R8");
        step(0, 0, 1, 0, 0, "R8");
        step(0, 0, 0, 0, 0, "R8");
        step(0, 1, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, "R8");
        // R9: collisions
        step(1, 1, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, "R9");
        step(1, 1, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, "R9");
        // R11: reset while armed
        step(1, 0, 0, 0, 0, "R11");
        step(0, 0, 0, 0, 1, "R11");
        step(0, 0, 0, 0, 0, "R11");
        // R10: legacy pulse length and restart
        step(1, 0, 0, 0, 0, "R10");
        step(0, 1, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, "R10");
        step(1, 0, 0, 0, 0, "R10");
        for (int i = 0; i < LEN + 2; i++) begin
            step(0, 0, 0, 0, 0, "R10");
        end
        step(0, 1, 1, 0, 0, "R10");
        step(0, 0, 0, 0, 0, "R10");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule